// File: doc/BRIEF.md
# Nonvolatile Memory Write Controller

This block holds the control and status state that a CPU uses to drive write and erase operations on an on-chip nonvolatile memory. Through a byte-wide register port the CPU loads a target address and a data byte, then sets up a control register. That register picks the target space, chooses write or erase, and carries a write-enable bit. A start bit launches the operation. A key written to a storage-less unlock register arms a one-shot gate, and a start is taken only while that gate is armed.

Once an operation is launched, the start bit doubles as a busy indicator. Only hardware can clear it, and it does so when the memory reports completion. At that moment a completion flag is raised and drives the interrupt output. The memory array is modelled by an internal stub that answers after a fixed number of cycles, with a longer count for erase. A warm reset (master or watchdog) that lands during an operation aborts it. It clears the address, data and control fields and sets an error bit. The error bit survives that warm reset.

Top module: `nvm_wrctl`

## Requirements
- R1: After power-on reset (`rst`), the control register (address 0), address bytes (addresses 2 low, 3 high) and data byte (address 4) all read 0x00, and `busy` and `irq` are low.
- R2: A read of the unlock register (address 1) always returns 0x00, whatever was written to it.
- R3: The space of a launched operation appears on `op_space`. It is 2 (configuration) when control bit 3 is set, whatever bit 4 holds. Otherwise it is 1 (program) when bit 4 is set, or 0 (data EEPROM) when bit 4 is clear.
- R4: When control bit 2 (erase enable) is set in the start write, `op_erase` is 1 and the operation takes the erase latency. When bit 2 is clear, `op_erase` is 0 and it is a write.
- R5: Writing 1 to control bit 0 (start) launches an operation only if the stored write-enable (bit 1) is already 1 and the unlock key 0xA5 was the last register write before it. Otherwise bit 0 reads back 0, `busy` stays low and no completion follows.
- R6: While an operation runs, a CPU write of 0 to control bit 0 has no effect, and `busy` stays high.
- R7: An operation keeps `busy` and bit 0 set for at least its latency, and for at most three cycles more. Then hardware clears bit 0 and sets the completion flag (bit 6).
- R8: The completion flag drives `irq`. It stays set until the CPU writes 0 to bit 6, and writing 1 there leaves it set.
- R9: If completion arrives in the same cycle as a CPU write of 0 to bit 6, the flag ends up set.
- R10: A warm reset (`rst_warm`) during an operation sets the error bit (bit 5) and clears bit 0 and the other control fields. It also clears the address and data registers. No completion flag follows.
- R11: The error bit is kept through any later warm reset and through CPU writes of 1 to bit 5. It is cleared only by a CPU write of 0 to bit 5 or by power-on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| rst_warm | input | 1 | Master/watchdog reset, synchronous, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data for the address of the previous cycle |
| busy | output | 1 | Operation in progress (mirror of control bit 0) |
| irq | output | 1 | Completion interrupt flag |
| op_space | output | 2 | Space of the launched operation: 0 data, 1 program, 2 config |
| op_erase | output | 1 | Launched operation is an erase |

## Verification
Two updates can land in the same cycle: the completion pulse from the memory stub, and a CPU write that clears the completion flag. To force the overlap, the bench keeps a flag-clearing control write asserted on every cycle of an operation. It drops that write at the first sample where `busy` reads low, so the last write coincided with the completion edge. The flag must read back set afterwards. A second overlap, a warm reset against a running operation, is judged on the error bit and on the absence of any later completion.

// File: rtl/nvm_wrctl_pkg.sv
package nvm_wrctl_pkg;

  typedef enum logic [1:0] {
    SPACE_DATA = 2'd0,
    SPACE_PROG = 2'd1,
    SPACE_CFG  = 2'd2
  } nvm_space_e;

  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] RA_CTRL    = 3'd0;
  localparam logic [REG_AW-1:0] RA_UNLOCK  = 3'd1;
  localparam logic [REG_AW-1:0] RA_ADDR_LO = 3'd2;
  localparam logic [REG_AW-1:0] RA_ADDR_HI = 3'd3;
  localparam logic [REG_AW-1:0] RA_DATA    = 3'd4;

  localparam int CB_START = 0;
  localparam int CB_WREN  = 1;
  localparam int CB_ERASE = 2;
  localparam int CB_CFG   = 3;
  localparam int CB_PROG  = 4;
  localparam int CB_ERR   = 5;
  localparam int CB_FLAG  = 6;

  // configuration select wins over the memory-type select
  function automatic nvm_space_e pick_space(input logic cfg, input logic prog);
    if (cfg)       return SPACE_CFG;
    else if (prog) return SPACE_PROG;
    else           return SPACE_DATA;
  endfunction

endpackage

// File: rtl/nvm_addr_data.sv
module nvm_addr_data
  import nvm_wrctl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rst_warm,
  input  logic              we,
  input  logic [REG_AW-1:0] waddr,
  input  logic [7:0]        wdata,
  output logic [15:0]       addr_o,
  output logic [DATA_W-1:0] data_o
);

  localparam logic [15:0] AMASK = 16'((32'h1 << ADDR_W) - 1);

  logic [7:0]        addr_b [2];
  logic [DATA_W-1:0] data_q;

  for (genvar b = 0; b < 2; b++) begin : g_abyte
    localparam logic [REG_AW-1:0] MY_RA = (b == 0) ? RA_ADDR_LO : RA_ADDR_HI;
    always_ff @(posedge clk) begin
      if (rst || rst_warm) begin
        addr_b[b] <= '0;
      end else if (we && waddr == MY_RA) begin
        addr_b[b] <= wdata & AMASK[b*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || rst_warm) begin
      data_q <= '0;
    end else if (we && waddr == RA_DATA) begin
      data_q <= wdata[DATA_W-1:0];
    end
  end

  assign addr_o = {addr_b[1], addr_b[0]};
  assign data_o = data_q;

  a_r10_addr_cleared: assert property (@(posedge clk) disable iff (rst)
    rst_warm |=> (addr_o == 16'h0) && (data_o == '0));

endmodule

// File: rtl/nvm_ctrl.sv
module nvm_ctrl
  import nvm_wrctl_pkg::*;
#(
  parameter logic [7:0] KEY = 8'hA5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rst_warm,
  input  logic              we,
  input  logic [REG_AW-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic              done_i,
  output logic [7:0]        ctrl_o,
  output logic              busy_o,
  output logic              launch_o,
  output nvm_space_e        op_space_o,
  output logic              op_erase_o,
  output logic              irq_o
);

  logic busy_q, wren_q, erase_q, cfg_q, prog_q, err_q, flag_q, armed_q, launch_q;
  logic op_erase_q;
  nvm_space_e op_space_q;

  logic wr_ctrl, wr_key, start_ok;

  assign wr_ctrl  = we && (waddr == RA_CTRL);
  assign wr_key   = we && (waddr == RA_UNLOCK) && (wdata == KEY);
  assign start_ok = wr_ctrl && wdata[CB_START] && !busy_q && wren_q && armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      wren_q     <= 1'b0;
      erase_q    <= 1'b0;
      cfg_q      <= 1'b0;
      prog_q     <= 1'b0;
      err_q      <= 1'b0;
      flag_q     <= 1'b0;
      armed_q    <= 1'b0;
      launch_q   <= 1'b0;
      op_erase_q <= 1'b0;
      op_space_q <= SPACE_DATA;
    end else if (rst_warm) begin
      busy_q     <= 1'b0;
      wren_q     <= 1'b0;
      erase_q    <= 1'b0;
      cfg_q      <= 1'b0;
      prog_q     <= 1'b0;
      armed_q    <= 1'b0;
      launch_q   <= 1'b0;
      op_erase_q <= 1'b0;
      op_space_q <= SPACE_DATA;
      err_q      <= err_q | (busy_q & ~done_i);
      flag_q     <= flag_q | done_i;
    end else begin
      launch_q <= start_ok;
      if (wr_ctrl) begin
        wren_q  <= wdata[CB_WREN];
        erase_q <= wdata[CB_ERASE];
        cfg_q   <= wdata[CB_CFG];
        prog_q  <= wdata[CB_PROG];
      end
      if (wr_key)  armed_q <= 1'b1;
      else if (we) armed_q <= 1'b0;
      if (done_i)        busy_q <= 1'b0;
      else if (start_ok) busy_q <= 1'b1;
      if (start_ok) begin
        op_space_q <= pick_space(wdata[CB_CFG], wdata[CB_PROG]);
        op_erase_q <= wdata[CB_ERASE];
      end
      if (done_i)                           flag_q <= 1'b1;
      else if (wr_ctrl && !wdata[CB_FLAG])  flag_q <= 1'b0;
      if (wr_ctrl && !wdata[CB_ERR])        err_q  <= 1'b0;
    end
  end

  assign ctrl_o     = {1'b0, flag_q, err_q, prog_q, cfg_q, erase_q, wren_q, busy_q};
  assign busy_o     = busy_q;
  assign launch_o   = launch_q;
  assign op_space_o = op_space_q;
  assign op_erase_o = op_erase_q;
  assign irq_o      = flag_q;

  a_r5_start_gated: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> ($past(wren_q) && $past(armed_q)));

  a_r6_busy_sticky: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !done_i && !rst_warm) |=> busy_q);

  a_r7_done_completes: assert property (@(posedge clk) disable iff (rst)
    done_i |=> (!busy_q && flag_q));

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !(we && waddr == RA_CTRL && !wdata[CB_FLAG])) |=> flag_q);

  a_r10_abort_err: assert property (@(posedge clk) disable iff (rst)
    (rst_warm && busy_q && !done_i) |=> err_q);

  a_r11_err_survives: assert property (@(posedge clk) disable iff (rst)
    (err_q && !(we && waddr == RA_CTRL && !wdata[CB_ERR])) |=> err_q);

endmodule

// File: rtl/nvm_array_stub.sv
module nvm_array_stub #(
  parameter int WR_LAT = 6,
  parameter int ER_LAT = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic abort,
  input  logic launch_i,
  input  logic erase_i,
  output logic done_o
);

  localparam int MAXLAT = (ER_LAT > WR_LAT) ? ER_LAT : WR_LAT;
  localparam int CW     = $clog2(MAXLAT + 1);

  logic [CW-1:0] cnt_q;
  logic          active_q;
  logic          done_q;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (launch_i) begin
        active_q <= 1'b1;
        cnt_q    <= erase_i ? CW'(ER_LAT) : CW'(WR_LAT);
      end else if (active_q) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          done_q   <= 1'b1;
          active_q <= 1'b0;
        end
      end
    end
  end

  assign done_o = done_q;

  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r10_no_done_after_abort: assert property (@(posedge clk) disable iff (rst)
    abort |=> !done_o);

endmodule

// File: rtl/nvm_wrctl.sv
module nvm_wrctl
  import nvm_wrctl_pkg::*;
#(
  parameter int         ADDR_W = 16,
  parameter int         WR_LAT = 6,
  parameter int         ER_LAT = 10,
  parameter logic [7:0] KEY    = 8'hA5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rst_warm,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic        busy,
  output logic        irq,
  output logic [1:0]  op_space,
  output logic        op_erase
);

  logic [7:0]  ctrl_w;
  logic [15:0] addr_w;
  logic [7:0]  data_w;
  logic        launch_w, done_w, busy_w, irq_w, erase_w;
  nvm_space_e  space_w;
  logic [7:0]  rdata_q;

  nvm_addr_data #(.ADDR_W(ADDR_W), .DATA_W(8)) u_regs (
    .clk(clk), .rst(rst), .rst_warm(rst_warm),
    .we(reg_we), .waddr(reg_addr), .wdata(reg_wdata),
    .addr_o(addr_w), .data_o(data_w)
  );

  nvm_ctrl #(.KEY(KEY)) u_ctrl (
    .clk(clk), .rst(rst), .rst_warm(rst_warm),
    .we(reg_we), .waddr(reg_addr), .wdata(reg_wdata),
    .done_i(done_w), .ctrl_o(ctrl_w), .busy_o(busy_w), .launch_o(launch_w),
    .op_space_o(space_w), .op_erase_o(erase_w), .irq_o(irq_w)
  );

  nvm_array_stub #(.WR_LAT(WR_LAT), .ER_LAT(ER_LAT)) u_array (
    .clk(clk), .rst(rst), .abort(rst_warm),
    .launch_i(launch_w), .erase_i(erase_w), .done_o(done_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      case (reg_addr)
        RA_CTRL:    rdata_q <= ctrl_w;
        RA_ADDR_LO: rdata_q <= addr_w[7:0];
        RA_ADDR_HI: rdata_q <= addr_w[15:8];
        RA_DATA:    rdata_q <= data_w;
        default:    rdata_q <= 8'h00;
      endcase
    end
  end

  assign reg_rdata = rdata_q;
  assign busy      = busy_w;
  assign irq       = irq_w;
  assign op_space  = space_w;
  assign op_erase  = erase_w;

  a_r2_unlock_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == RA_UNLOCK) |=> (reg_rdata == 8'h00));

endmodule

// File: tb/nvm_wrctl_bench.sv
module nvm_wrctl_bench;

  localparam int         WR_LAT = 6;
  localparam int         ER_LAT = 10;
  localparam logic [7:0] KEY    = 8'hA5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rst_warm = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       busy, irq, op_erase;
  logic [1:0] op_space;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  nvm_wrctl #(.ADDR_W(16), .WR_LAT(WR_LAT), .ER_LAT(ER_LAT), .KEY(KEY)) u_nvm_wrctl (
    .clk(clk), .rst(rst), .rst_warm(rst_warm),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .busy(busy), .irq(irq),
    .op_space(op_space), .op_erase(op_erase)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic por();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic warm_pulse();
    @(negedge clk);
    rst_warm = 1'b1;
    @(negedge clk);
    rst_warm = 1'b0;
  endtask

  task automatic launch(input logic [7:0] f);
    wr(3'd0, f);
    wr(3'd1, KEY);
    wr(3'd0, f | 8'h01);
  endtask

  // R1
  task automatic t_reset();
    logic [7:0] v;
    por();
    chk("R1 busy", busy, 0);
    chk("R1 irq", irq, 0);
    rd(3'd0, v); chk("R1 ctrl", v, 8'h00);
    rd(3'd2, v); chk("R1 addr_lo", v, 8'h00);
    rd(3'd3, v); chk("R1 addr_hi", v, 8'h00);
    rd(3'd4, v); chk("R1 data", v, 8'h00);
  endtask

  // R2
  task automatic t_unlock_read();
    logic [7:0] v;
    wr(3'd1, KEY);
    rd(3'd1, v); chk("R2 after key", v, 8'h00);
    wr(3'd1, 8'hFF);
    rd(3'd1, v); chk("R2 after ff", v, 8'h00);
  endtask

  // R5
  task automatic t_gate();
    logic [7:0] v;
    wr(3'd0, 8'h00); wr(3'd1, KEY); wr(3'd0, 8'h01);
    rd(3'd0, v); chk("R5 no wren ctrl", v, 8'h00);
    chk("R5 no wren busy", busy, 0);
    wr(3'd0, 8'h02); wr(3'd0, 8'h03);
    rd(3'd0, v); chk("R5 no key ctrl", v, 8'h02);
    wr(3'd0, 8'h02); wr(3'd1, KEY); wr(3'd4, 8'h11); wr(3'd0, 8'h03);
    rd(3'd0, v); chk("R5 stale key ctrl", v, 8'h02);
    repeat (ER_LAT + 4) @(negedge clk);
    chk("R5 no completion irq", irq, 0);
    chk("R5 no completion busy", busy, 0);
  endtask

  // R3 R4 R6 R7 R8
  task automatic t_op(input logic cfg, input logic prog, input logic er,
                      input int exp_space, input int lat);
    logic [7:0] f, v;
    int c0, d;
    f = 8'h02 | (8'(er) << 2) | (8'(cfg) << 3) | (8'(prog) << 4);
    wr(3'd2, 8'h34); wr(3'd3, 8'h12); wr(3'd4, 8'h5A);
    launch(f);
    c0 = cyc;
    chk("R7 busy after start", busy, 1);
    chk("R3 op_space", op_space, exp_space);
    chk("R4 op_erase", op_erase, er);
    wr(3'd0, f);
    chk("R6 busy after zero write", busy, 1);
    for (int i = 0; i < 60 && busy; i++) @(negedge clk);
    d = cyc - c0;
    chk("R7 latency lower", (d >= lat) ? 1 : 0, 1);
    chk("R7 latency upper", (d <= lat + 3) ? 1 : 0, 1);
    rd(3'd0, v); chk("R7 ctrl after done", v, f | 8'h40);
    chk("R8 irq set", irq, 1);
    rd(3'd2, v); chk("R1 addr_lo readback", v, 8'h34);
    wr(3'd0, f | 8'h40);
    rd(3'd0, v); chk("R8 write one keeps flag", v, f | 8'h40);
    wr(3'd0, f);
    rd(3'd0, v); chk("R8 write zero clears", v, f);
    chk("R8 irq cleared", irq, 0);
  endtask

  // R9
  task automatic t_collide();
    logic [7:0] v;
    launch(8'h02);
    reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h02;
    for (int i = 0; i < 60 && busy; i++) @(negedge clk);
    reg_we = 1'b0;
    rd(3'd0, v); chk("R9 flag wins", v, 8'h42);
    chk("R9 irq", irq, 1);
    wr(3'd0, 8'h02);
  endtask

  // R10 R11
  task automatic t_abort();
    logic [7:0] v;
    wr(3'd2, 8'h77); wr(3'd4, 8'h99);
    launch(8'h06);
    repeat (2) @(negedge clk);
    warm_pulse();
    rd(3'd0, v); chk("R10 ctrl after abort", v, 8'h20);
    rd(3'd2, v); chk("R10 addr cleared", v, 8'h00);
    rd(3'd4, v); chk("R10 data cleared", v, 8'h00);
    repeat (ER_LAT + 4) @(negedge clk);
    chk("R10 no irq", irq, 0);
    chk("R10 no busy", busy, 0);
    warm_pulse();
    rd(3'd0, v); chk("R11 err through idle warm reset", v, 8'h20);
    wr(3'd0, 8'h20);
    rd(3'd0, v); chk("R11 write one keeps err", v, 8'h20);
    wr(3'd0, 8'h00);
    rd(3'd0, v); chk("R11 write zero clears err", v, 8'h00);
    wr(3'd0, 8'h02);
    launch(8'h02);
    @(negedge clk);
    warm_pulse();
    rd(3'd0, v); chk("R10 second abort", v, 8'h20);
    por();
    rd(3'd0, v); chk("R11 power-on clears err", v, 8'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_unlock_read();
    t_gate();
    t_op(1'b0, 1'b0, 1'b0, 0, WR_LAT);
    t_op(1'b0, 1'b1, 1'b1, 1, ER_LAT);
    t_op(1'b1, 1'b0, 1'b0, 2, WR_LAT);
    t_op(1'b1, 1'b1, 1'b0, 2, WR_LAT);
    t_collide();
    t_abort();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule